// File: doc/BRIEF.md
# Byte-Stream Configuration Loader

This block feeds a programmable device's parallel configuration port from a byte-wide receive/transmit FIFO bridge while that device is still blank. Each byte that the FIFO side offers is pulled in with an active-low read strobe and then presented on the configuration data output together with a one-clock write pulse. All inputs are assumed synchronous to `clk`.

During the first part of a load the host can ask questions in-band. The block answers each byte it receives with a reply byte whose bit 0 carries either the device's DONE level (query byte with bit 0 = 1) or the device size strap (query byte with bit 0 = 0). After four back-to-back bytes with bit 0 clear, replies stop for the rest of the load, so the bulk of the image streams through without replies. When DONE goes high the block drops every strobe and stops driving the shared data bus; the target's startup sequence must therefore raise DONE as its final step.

Top module: `cfg_stream_loader`

## Requirements
- R1: When `done_i` is sampled high at a clock edge, from that edge on `rd_n` is high, `tx_wr` and `cfg_wr` are low and `fifo_oe` is low, and no read starts while `done_i` stays high, even with `rx_has_n` low.
- R2: Each byte read while `done_i` is low appears on `cfg_data` with `cfg_wr` high for exactly one clock, starting at the edge that ends the read strobe.
- R3: While replies are on, a received byte with bit 0 = 1 produces a reply whose bit 0 equals `done_i` (0 during a load).
- R4: While replies are on, a received byte with bit 0 = 0 produces a reply whose bit 0 equals `size_large` (0 = small device, 1 = large device).
- R5: The byte completing a run of four consecutive bytes with bit 0 = 0 is still answered; every later byte gets no reply until reset, whatever its bit 0.
- R6: A received byte with bit 0 = 1 restarts the count of consecutive bit-0-clear bytes from zero.
- R7: A pending reply is written (`tx_wr` high for one clock) only on the edge after `tx_space_n` is seen low; no new read begins until the reply is written and `fifo_oe` is released.
- R8: `rd_n` is held low for `RD_CLKS` clocks (default 2) and `fifo_din` is sampled on the edge ending the last of them.
- R9: Bits 7..1 of every reply byte on `fifo_dout` are zero while `fifo_oe` is high.
- R10: Synchronous reset `rst` sets `rd_n` high, `cfg_wr`, `tx_wr`, `fifo_oe` low, turns replies back on and clears the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_has_n | input | 1 | Low when the receive FIFO holds a byte |
| tx_space_n | input | 1 | Low when the transmit FIFO can accept a byte |
| fifo_din | input | DW | Data bus as driven by the FIFO bridge |
| rd_n | output | 1 | Active-low receive read strobe |
| tx_wr | output | 1 | Transmit write strobe, one clock |
| fifo_dout | output | DW | Reply byte toward the FIFO bridge |
| fifo_oe | output | 1 | High while the block drives the data bus |
| cfg_data | output | DW | Configuration data byte |
| cfg_wr | output | 1 | Configuration write pulse, one clock |
| done_i | input | 1 | Target device DONE level |
| size_large | input | 1 | Size strap, 1 = large device |

## Verification
`rd_n` falls on the first edge that sees `rx_has_n` low and rises `RD_CLKS` edges later; `cfg_wr`, `cfg_data` and, when a reply is due, `fifo_oe` with the reply byte all change on that same rising edge of `rd_n`, and `tx_wr` rises one edge after `tx_space_n` is seen low, with `fifo_oe` falling one edge after that. A DONE assertion takes effect on the very next edge. The bench drives on the falling clock edge and samples on the falling edge right after the edge where each result is due, counting strobe clocks and holding `tx_space_n` high for several clocks to show that nothing moves early.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
  typedef enum logic [2:0] {
    LD_IDLE  = 3'd0,
    LD_READ  = 3'd1,
    LD_REPLY = 3'd2,
    LD_FLUSH = 3'd3,
    LD_OFF   = 3'd4
  } ld_state_t;
endpackage

// File: rtl/cfg_ld_rdstrobe.sv
// Times the active-low receive read strobe.
module cfg_ld_rdstrobe #(
  parameter int RD_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  output logic rd_n,
  output logic last
);
  localparam int CW = $clog2(RD_CLKS + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(RD_CLKS - 1);

  logic [CW-1:0] cnt;

  assign last = !rd_n && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_n <= 1'b1;
      cnt  <= '0;
    end else if (abort) begin
      rd_n <= 1'b1;
      cnt  <= '0;
    end else if (rd_n) begin
      if (start) begin
        rd_n <= 1'b0;
        cnt  <= '0;
      end
    end else if (cnt == LAST_CNT) begin
      rd_n <= 1'b1;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_ld_echo.sv
// Tracks the run of bit-0-clear bytes and latches replies off.
module cfg_ld_echo #(
  parameter int ZERO_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic lsb,
  output logic echo_on
);
  localparam int ZW = $clog2(ZERO_RUN + 1);
  localparam logic [ZW-1:0] RUN_LAST = ZW'(ZERO_RUN - 1);

  logic [ZW-1:0] zcnt;
  logic          echo_off;

  assign echo_on = !echo_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      zcnt     <= '0;
      echo_off <= 1'b0;
    end else if (take) begin
      if (lsb) begin
        zcnt <= '0;
      end else if (zcnt == RUN_LAST) begin
        zcnt     <= '0;
        echo_off <= 1'b1;
      end else begin
        zcnt <= zcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_ld_pkg::*;
#(
  parameter int DW       = 8,
  parameter int RD_CLKS  = 2,
  parameter int ZERO_RUN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_has_n,
  input  logic          tx_space_n,
  input  logic [DW-1:0] fifo_din,
  output logic          rd_n,
  output logic          tx_wr,
  output logic [DW-1:0] fifo_dout,
  output logic          fifo_oe,
  output logic [DW-1:0] cfg_data,
  output logic          cfg_wr,
  input  logic          done_i,
  input  logic          size_large
);
  localparam logic [DW-2:0] PAD = '0;

  ld_state_t state;
  logic      rd_start;
  logic      rd_last;
  logic      take;
  logic      echo_on;
  logic      reply_bit;

  assign rd_start  = (state == LD_IDLE) && !rx_has_n && !done_i;
  assign take      = (state == LD_READ) && rd_last && !done_i;
  assign reply_bit = fifo_din[0] ? done_i : size_large;

  cfg_ld_rdstrobe #(.RD_CLKS(RD_CLKS)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .start (rd_start),
    .abort (done_i),
    .rd_n  (rd_n),
    .last  (rd_last)
  );

  cfg_ld_echo #(.ZERO_RUN(ZERO_RUN)) u_echo (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .lsb     (fifo_din[0]),
    .echo_on (echo_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LD_IDLE;
      cfg_data  <= '0;
      cfg_wr    <= 1'b0;
      tx_wr     <= 1'b0;
      fifo_oe   <= 1'b0;
      fifo_dout <= '0;
    end else begin
      cfg_wr <= 1'b0;
      tx_wr  <= 1'b0;
      if (done_i) begin
        state   <= LD_OFF;
        fifo_oe <= 1'b0;
      end else begin
        unique case (state)
          LD_IDLE: if (!rx_has_n) state <= LD_READ;
          LD_READ: if (rd_last) begin
            cfg_data <= fifo_din;
            cfg_wr   <= 1'b1;
            if (echo_on) begin
              fifo_dout <= {PAD, reply_bit};
              fifo_oe   <= 1'b1;
              state     <= LD_REPLY;
            end else begin
              state <= LD_IDLE;
            end
          end
          LD_REPLY: if (!tx_space_n) begin
            tx_wr <= 1'b1;
            state <= LD_FLUSH;
          end
          LD_FLUSH: begin
            fifo_oe <= 1'b0;
            state   <= LD_IDLE;
          end
          default: state <= LD_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_ld_chk.sv
module cfg_ld_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_space_n,
  input logic          rd_n,
  input logic          tx_wr,
  input logic [DW-1:0] fifo_dout,
  input logic          fifo_oe,
  input logic          cfg_wr,
  input logic          done_i
);
  // R1
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (rd_n && !tx_wr && !cfg_wr && !fifo_oe));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n) && !done_i) |=> !rd_n);

  // R7
  tx_wait_chk: assert property (@(posedge clk) disable iff (rst)
    tx_wr |-> $past(!tx_space_n));

  // R7
  no_read_during_reply_chk: assert property (@(posedge clk) disable iff (rst)
    !(fifo_oe && !rd_n));

  // R9
  reply_pad_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_oe |-> (fifo_dout[DW-1:1] == '0));

  // R2
  cfg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !cfg_wr);
endmodule

bind cfg_stream_loader cfg_ld_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tx_space_n (tx_space_n),
  .rd_n       (rd_n),
  .tx_wr      (tx_wr),
  .fifo_dout  (fifo_dout),
  .fifo_oe    (fifo_oe),
  .cfg_wr     (cfg_wr),
  .done_i     (done_i)
);

// File: tb/cfg_stream_loader_bench.sv
module cfg_stream_loader_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_has_n = 1'b1;
  logic          tx_space_n = 1'b1;
  logic [DW-1:0] fifo_din = '0;
  logic          rd_n, tx_wr, fifo_oe, cfg_wr;
  logic [DW-1:0] fifo_dout, cfg_data;
  logic          done_i = 1'b0;
  logic          size_large = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cfg_stream_loader #(.DW(DW), .RD_CLKS(2), .ZERO_RUN(4)) u_cfg_stream_loader (
    .clk(clk), .rst(rst), .rx_has_n(rx_has_n), .tx_space_n(tx_space_n),
    .fifo_din(fifo_din), .rd_n(rd_n), .tx_wr(tx_wr), .fifo_dout(fifo_dout),
    .fifo_oe(fifo_oe), .cfg_data(cfg_data), .cfg_wr(cfg_wr),
    .done_i(done_i), .size_large(size_large)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One byte through the loader; echo_exp says whether a reply is due.
  task automatic xfer(input logic [7:0] b, input bit echo_exp,
                      input logic [7:0] rep_exp, input string req);
    int n = 0;
    int lowc = 0;
    @(negedge clk);
    fifo_din = b;
    rx_has_n = 1'b0;
    while (rd_n && n < 20) begin @(negedge clk); n++; end
    while (!rd_n && lowc < 20) begin lowc++; @(negedge clk); end
    // R8: two strobe clocks
    chk(lowc == 2, "R8", "read strobe clocks", lowc, 2);
    // R2: byte forwarded with one-clock pulse
    chk(cfg_wr && cfg_data == b, "R2", "cfg byte", {cfg_wr, cfg_data}, {1'b1, b});
    fifo_din = 8'hA5;
    if (echo_exp) begin
      chk(fifo_oe == 1'b1, req, "reply pending", fifo_oe, 1);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        // R7: no write without space, no new read meanwhile
        chk(!tx_wr && rd_n && fifo_oe, "R7", "wait for space",
            {tx_wr, rd_n, fifo_oe}, 3'b011);
      end
      chk(!cfg_wr, "R2", "cfg pulse one clock", cfg_wr, 0);
      rx_has_n = 1'b1;
      tx_space_n = 1'b0;
      @(negedge clk);
      chk(tx_wr && fifo_dout == rep_exp, req, "reply byte",
          {tx_wr, fifo_dout}, {1'b1, rep_exp});
      tx_space_n = 1'b1;
      @(negedge clk);
      chk(!tx_wr && !fifo_oe, "R7", "reply done", {tx_wr, fifo_oe}, 0);
    end else begin
      rx_has_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
        chk(!fifo_oe && !tx_wr, req, "no reply", {fifo_oe, tx_wr}, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk(rd_n && !cfg_wr && !tx_wr && !fifo_oe, "R10", "reset outputs",
        {rd_n, cfg_wr, tx_wr, fifo_oe}, 4'b1000);
  endtask

  task automatic t_status();
    xfer(8'h31, 1'b1, 8'h00, "R3");
    size_large = 1'b1;
    xfer(8'h30, 1'b1, 8'h01, "R4");
    size_large = 1'b0;
    xfer(8'h30, 1'b1, 8'h00, "R4");
    size_large = 1'b1;
  endtask

  task automatic t_run();
    // run count is 2 here; an odd byte clears it
    xfer(8'h31, 1'b1, 8'h00, "R6");
    xfer(8'h30, 1'b1, 8'h01, "R6");
    xfer(8'h32, 1'b1, 8'h01, "R6");
    xfer(8'h34, 1'b1, 8'h01, "R6");
    xfer(8'h41, 1'b1, 8'h00, "R6");
    xfer(8'hF0, 1'b1, 8'h01, "R5");
    xfer(8'h02, 1'b1, 8'h01, "R5");
    xfer(8'h30, 1'b1, 8'h01, "R5");
    xfer(8'hAA, 1'b1, 8'h01, "R5");
    xfer(8'h30, 1'b0, 8'h00, "R5");
    xfer(8'h31, 1'b0, 8'h00, "R5");
    xfer(8'h7F, 1'b0, 8'h00, "R5");
  endtask

  task automatic t_reset_reenable();
    do_reset();
    xfer(8'h30, 1'b1, 8'h01, "R10");
  endtask

  task automatic t_done();
    int n = 0;
    @(negedge clk);
    fifo_din = 8'h55;
    rx_has_n = 1'b0;
    while (rd_n && n < 20) begin @(negedge clk); n++; end
    done_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      // R1: quiet while done high
      chk(rd_n && !cfg_wr && !tx_wr && !fifo_oe, "R1", "quiet after done",
          {rd_n, cfg_wr, tx_wr, fifo_oe}, 4'b1000);
    end
    rx_has_n = 1'b1;
    done_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    t_status();
    t_run();
    t_reset_reenable();
    t_done();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule